// File: doc/BRIEF.md
# Clear-on-Read Interrupt Controller

This block gathers one-cycle event pulses from sixteen internal sources into a sticky pending register. An enable register chooses which of those pending bits may pull the shared interrupt line low. The line is active low and open drain: it is pulled to 0 while any enabled bit is pending and released otherwise. It follows the register contents directly, with no dependence on bus activity.

Software uses a small read/write port with one address bit. Address 0 is the pending register. It is read-only, and any read of it returns every pending bit and empties the whole register in one step. Address 1 is the enable register, which can be read and written. An event that lands in the same cycle as a pending-register read is not in that read's data. It stays pending afterwards, so no event is lost.

Top module: `cor_irq_ctrl`

## Requirements
- R1: After reset the pending register and the enable register are all zeros, irq_n_o is 1 and irq_oe_o is 0.
- R2: A 1 on event_i[k] in a cycle sets pending bit k at the next clock edge. Bits accumulate and stay set until a pending read.
- R3: While rd_en_i=1 and addr_i=0, rdata_o shows all pending bits in that same cycle. At the following edge every pending bit is cleared.
- R4: An event that arrives during a pending read is absent from that read's data and is pending after the clear.
- R5: A write with addr_i=1 loads wdata_i into the enable register at the clock edge. A read with addr_i=1 returns it and leaves the pending register unchanged.
- R6: irq_n_o is 0 exactly when some bit is both pending and enabled, in the same cycle as the register contents.
- R7: A pending bit whose enable bit is 0 still records its event but does not pull irq_n_o low.
- R8: A write with addr_i=0 changes neither the pending register nor the enable register.
- R9: irq_oe_o, the pull-down enable, is 1 exactly when irq_n_o is 0.
- R10: rdata_o is 0 in any cycle where rd_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 16 | One-cycle event pulses, one bit per source |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0: pending register, 1: enable register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the strobe cycle |
| irq_n_o | output | 1 | Interrupt level, active low (0 = pulled down, 1 = released) |
| irq_oe_o | output | 1 | Pull-down enable for an open-drain pad |

## Verification
A pending bit held in a wrong state shows up on irq_n_o in the same cycle if its enable bit is set. It also shows up in the next pending read, so the bench enables sources and reads back after each scenario. A clear that fails, or one that drops a colliding event, shows up on the second of two back-to-back reads one cycle later. A corrupted enable register shows up on the next enable read and on the interrupt line.

// File: rtl/cor_irq_pkg.sv
package cor_irq_pkg;
  localparam int unsigned NUM_SRC = 16;
  localparam logic ADDR_PEND = 1'b0;
  localparam logic ADDR_EN   = 1'b1;
endpackage

// File: rtl/cor_irq_pend.sv
module cor_irq_pend #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    // set wins over clear so a colliding event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q & ~clr_i) | set_i[g];
    end
    assign pend_o[g] = bit_q;
  end
endmodule

// File: rtl/cor_irq_regif.sv
module cor_irq_regif #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic         addr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] pend_i,
  output logic         pend_clr_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] rdata_o
);
  import cor_irq_pkg::*;

  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          en_q <= '0;
    else if (wr_en_i && addr_i == ADDR_EN) en_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) rdata_o = (addr_i == ADDR_PEND) ? pend_i : en_q;
  end

  assign pend_clr_o = rd_en_i && (addr_i == ADDR_PEND);
  assign en_o       = en_q;
endmodule

// File: rtl/cor_irq_out.sv
module cor_irq_out #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_n_o,
  output logic         irq_oe_o
);
  logic active;
  assign active   = |(pend_i & en_i);
  assign irq_oe_o = active;
  assign irq_n_o  = ~active;
endmodule

// File: rtl/cor_irq_ctrl.sv
module cor_irq_ctrl #(
  parameter int unsigned N = cor_irq_pkg::NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic         addr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] rdata_o,
  output logic         irq_n_o,
  output logic         irq_oe_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;
  logic         pend_clr;

  cor_irq_pend #(.N(N)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (event_i),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  cor_irq_regif #(.N(N)) i_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pend_i     (pend_q),
    .pend_clr_o (pend_clr),
    .en_o       (en_q),
    .rdata_o    (rdata_o)
  );

  cor_irq_out #(.N(N)) i_out (
    .pend_i   (pend_q),
    .en_i     (en_q),
    .irq_n_o  (irq_n_o),
    .irq_oe_o (irq_oe_o)
  );
endmodule

// File: rtl/cor_irq_ctrl_chk.sv
module cor_irq_ctrl_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] event_i,
  input logic         rd_en_i,
  input logic         wr_en_i,
  input logic         addr_i,
  input logic [N-1:0] wdata_i,
  input logic [N-1:0] rdata_o,
  input logic         irq_n_o,
  input logic         irq_oe_o,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] en_q
);
  assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((pend_q & $past(event_i)) == $past(event_i)));

  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_i) |=> ((pend_q & ~$past(event_i)) == '0));

  assert_read_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_i) |-> (rdata_o == pend_q));

  assert_en_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i) |=> (en_q == $past(wdata_i)));

  assert_pend_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && !rd_en_i && event_i == '0) |=> ($stable(pend_q) && $stable(en_q)));

  assert_irq_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_n_o == ((pend_q & en_q) == '0)));

  assert_oe_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o != irq_n_o));

  assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

bind cor_irq_ctrl cor_irq_ctrl_chk #(.N(N)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .event_i  (event_i),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_n_o  (irq_n_o),
  .irq_oe_o (irq_oe_o),
  .pend_q   (pend_q),
  .en_q     (en_q)
);

// File: tb/test_cor_irq_ctrl.sv
`timescale 1ns/1ps
module test_cor_irq_ctrl;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] event_i = '0;
  logic         rd_en_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         addr_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_n_o;
  logic         irq_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cor_irq_ctrl #(.N(N)) i_cor_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); event_i = v;
    @(negedge clk); event_i = '0;
  endtask

  // read; evt is driven during the read cycle
  task automatic rd(input logic a, input logic [N-1:0] evt, output logic [N-1:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a; event_i = evt;
    #1 d = rdata_o;
    @(negedge clk); rd_en_i = 1'b0; event_i = '0;
  endtask

  task automatic wr(input logic a, input logic [N-1:0] v);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = v;
    @(negedge clk); wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    #1;
    chk("R1 irq_n", irq_n_o, 1);
    chk("R1 irq_oe", irq_oe_o, 0);
    chk("R10 idle rdata", rdata_o, 0);
    rd(1'b1, '0, d); chk("R1 enable reset", d, 0);
    rd(1'b0, '0, d); chk("R1 pending reset", d, 0);
  endtask

  task automatic t_accumulate();
    logic [N-1:0] d;
    pulse(16'h0005);
    pulse(16'h0100);
    #1 chk("R7 masked no irq", irq_n_o, 1);
    rd(1'b0, '0, d); chk("R2 R3 accumulated read", d, 16'h0105);
    rd(1'b0, '0, d); chk("R3 cleared after read", d, 0);
  endtask

  task automatic t_collision();
    logic [N-1:0] d;
    pulse(16'h0001);
    rd(1'b0, 16'h8000, d); chk("R4 collide read data", d, 16'h0001);
    rd(1'b0, 16'h0000, d); chk("R4 collide event kept", d, 16'h8000);
    rd(1'b0, 16'h0000, d); chk("R3 empty after", d, 0);
  endtask

  task automatic t_enable();
    logic [N-1:0] d;
    wr(1'b1, 16'h00F0);
    rd(1'b1, '0, d); chk("R5 enable readback", d, 16'h00F0);
    #1 chk("R6 no pending no irq", irq_n_o, 1);
    pulse(16'h0010);
    #1 chk("R6 irq asserted", irq_n_o, 0);
    chk("R9 oe asserted", irq_oe_o, 1);
    rd(1'b1, '0, d); chk("R5 enable read keeps irq", irq_n_o, 0);
    rd(1'b0, '0, d); chk("R5 pending survived enable read", d, 16'h0010);
    #1 chk("R6 irq released after clear", irq_n_o, 1);
    chk("R9 oe released", irq_oe_o, 0);
  endtask

  task automatic t_masked_src();
    logic [N-1:0] d;
    pulse(16'h0002);
    #1 chk("R7 masked src no irq", irq_n_o, 1);
    wr(1'b1, 16'h00F2);
    #1 chk("R6 enabling pending asserts irq", irq_n_o, 0);
    rd(1'b0, '0, d); chk("R7 masked src recorded", d, 16'h0002);
    wr(1'b1, 16'h00F0);
  endtask

  task automatic t_pend_write();
    logic [N-1:0] d;
    pulse(16'h0004);
    wr(1'b0, 16'hFFFF);
    #1 chk("R10 idle rdata", rdata_o, 0);
    rd(1'b1, '0, d); chk("R8 enable unchanged", d, 16'h00F0);
    rd(1'b0, '0, d); chk("R8 pending unchanged", d, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_accumulate();
    t_collision();
    t_enable();
    t_masked_src();
    t_pend_write();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule